// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Snapshot Window

This block keeps the time of day and the calendar date in packed BCD. Internal counters hold seconds, minutes, hours, date, weekday, month, year and century. A chain of three dividers turns a 32.768 kHz enable into one step per second. Software never reads the counters directly. It reads and writes a 16-byte register window on a synchronous bus with a 4-bit address and separate write and read strobes. The window holds a copy of the counters, and that copy is refreshed one clock after each seconds step.

Software can set a hold bit in the control byte. While the bit is set, the copy stops changing but the counters keep running, so a multi-byte read always sees one consistent instant. Software sets the clock in the same way: it sets the hold bit, writes the fields it wants to change, and clears the bit. Only the fields written during the hold move into the counters, and the counters then continue from those values. A second input, meant for test, steps the seconds once per asserted cycle without going through the dividers.

Hours are kept internally in 24-hour form. They are converted to 12-hour form with a PM flag, or shown as-is, according to a format bit in the control byte.

Top module: `bcdcal_top`

## Requirements
- R1: With `fast_sec_en` low, the seconds value advances exactly once for every 32768 cycles in which `tick32k_en` is high (divide by 8, then 64, then 64), and not before.
- R2: Each cycle with `fast_sec_en` high advances the seconds counter by exactly one. When no step and no load occurs, the counters do not change.
- R3: Window map: 0x0 seconds (mask 0x7F), 0x2 minutes (0x7F), 0x4 hours (0x3F in 24-hour form, 0x9F in 12-hour form), 0x6 date (0x3F), 0x8 weekday (0x07), 0x9 month (0x1F), 0xA year (0xFF), 0xF century (0xFF), 0xE control (bit 3 hold, bit 1 24-hour form). Masked bits and all other addresses read 0 and ignore writes. Read data appears the cycle after `bus_rd` and holds until the next read.
- R4: While hold is 0, every window time and date byte equals the counters, in the selected hour form, from the cycle after each seconds step.
- R5: While hold is 1, the window bytes change only through software writes, and the counters keep advancing.
- R6: When hold is set in the same cycle as a seconds step, the refresh that belongs to that step still reaches the window, and the window then freezes.
- R7: When hold goes from 1 to 0, each field written during the hold is loaded into its counter. Fields not written keep counting undisturbed.
- R8: A field write made while hold is 0 never reaches the counters, and the next refresh overwrites it.
- R9: In 12-hour form (control bit 1 = 0), hours read 01 to 12 with bit 7 set for PM. 11 AM steps to 12 PM, and 11:59:59 PM steps to 12 AM and advances the date.
- R10: In 24-hour form, hours read 00 to 23, and 23:59:59 steps to 00:00:00 with a date advance.
- R11: Month lengths are 31, 30 or 28 days, and February has 29 days when the BCD year is a multiple of 4.
- R12: The weekday counts 1 to 7 and steps from 7 to 1 at each midnight.
- R13: Year 99 rolls to 00 and increments the century byte.
- R14: After reset the window reads 12:00:00 AM, date 01, weekday 7, month 01, year 00, century 20, control 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| fast_sec_en | input | 1 | Test step: advances seconds once per cycle when high |
| bus_addr | input | 4 | Window byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The directed cases cover the edges of every carry in the chain:
- If the month-length function were wrong, February in a leap year would skip day 29, or a 30-day month would show day 31.
- If 12-hour conversion were off by one, noon would show as 12 AM, or midnight would fail to advance the date.
- If the counters stopped during the hold, the time would fall behind once the hold is released.

Two cases target the hold logic:
- Setting the hold in the same cycle as a seconds step shows whether the refresh decision is taken at the step, and not after the hold lands.
- Writing one field during a hold shows whether only written fields are loaded. A design that loads the whole window would jump the seconds back to the frozen value.

Seeded random settings near minute, day and year boundaries, in both hour forms, then check every byte against a bench calendar model.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int NFIELD = 8;

    localparam logic [3:0] A_SEC  = 4'h0;
    localparam logic [3:0] A_MIN  = 4'h2;
    localparam logic [3:0] A_HR   = 4'h4;
    localparam logic [3:0] A_DATE = 4'h6;
    localparam logic [3:0] A_DOW  = 4'h8;
    localparam logic [3:0] A_MON  = 4'h9;
    localparam logic [3:0] A_YR   = 4'hA;
    localparam logic [3:0] A_CTRL = 4'hE;
    localparam logic [3:0] A_CEN  = 4'hF;

    localparam int HOLD_BIT = 3;
    localparam int H24_BIT  = 1;

    // field order: index 0 = seconds (lsb) ... index 7 = century (msb)
    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } caltime_t;

    localparam caltime_t TIME_AT_RESET = '{cen: 8'h20, yr: 8'h00, mon: 8'h01,
                                           dow: 8'h07, date: 8'h01, hr: 8'h00,
                                           min: 8'h00, sec: 8'h00};

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] tens, ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        else                return b + 8'd1;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] yb;
        yb = bcd2bin(yr);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] hr24_to_12(input logic [7:0] h);
        logic [6:0] hb;
        hb = bcd2bin(h & 8'h3F);
        if (hb == 7'd0)       return 8'h12;
        else if (hb < 7'd12)  return h & 8'h3F;
        else if (hb == 7'd12) return 8'h92;
        else                  return 8'h80 | bin2bcd(hb - 7'd12);
    endfunction

    function automatic logic [7:0] hr12_to_24(input logic [7:0] b);
        logic [6:0] hb;
        hb = bcd2bin(b & 8'h1F);
        if (hb == 7'd12)  hb = b[7] ? 7'd12 : 7'd0;
        else if (b[7])    hb = hb + 7'd12;
        return bin2bcd(hb);
    endfunction

    function automatic logic [7:0] field_mask(input logic [2:0] idx, input logic h24);
        case (idx)
            3'd0, 3'd1: return 8'h7F;
            3'd2:       return h24 ? 8'h3F : 8'h9F;
            3'd3:       return 8'h3F;
            3'd4:       return 8'h07;
            3'd5:       return 8'h1F;
            default:    return 8'hFF;
        endcase
    endfunction

    // returns {valid, index}
    function automatic logic [3:0] field_of(input logic [3:0] a);
        case (a)
            A_SEC:   return 4'b1_000;
            A_MIN:   return 4'b1_001;
            A_HR:    return 4'b1_010;
            A_DATE:  return 4'b1_011;
            A_DOW:   return 4'b1_100;
            A_MON:   return 4'b1_101;
            A_YR:    return 4'b1_110;
            A_CEN:   return 4'b1_111;
            default: return 4'b0_000;
        endcase
    endfunction

    function automatic caltime_t step_second(input caltime_t t);
        caltime_t r;
        r = t;
        if (t.sec < 8'h59) r.sec = bcd_inc(t.sec);
        else begin
            r.sec = 8'h00;
            if (t.min < 8'h59) r.min = bcd_inc(t.min);
            else begin
                r.min = 8'h00;
                if (t.hr < 8'h23) r.hr = bcd_inc(t.hr);
                else begin
                    r.hr  = 8'h00;
                    r.dow = (t.dow >= 8'h07) ? 8'h01 : bcd_inc(t.dow);
                    if (t.date < month_len(t.mon, t.yr)) r.date = bcd_inc(t.date);
                    else begin
                        r.date = 8'h01;
                        if (t.mon < 8'h12) r.mon = bcd_inc(t.mon);
                        else begin
                            r.mon = 8'h01;
                            if (t.yr < 8'h99) r.yr = bcd_inc(t.yr);
                            else begin
                                r.yr  = 8'h00;
                                r.cen = (t.cen >= 8'h99) ? 8'h00 : bcd_inc(t.cen);
                            end
                        end
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bcdcal_prescale.sv
module bcdcal_prescale #(
    parameter int DIV0 = 8,
    parameter int DIV1 = 64,
    parameter int DIV2 = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic test_sec_en,
    output logic sec_pulse
);
    localparam int NSTG = 3;

    logic [NSTG:0] stage_en;

    assign stage_en[0] = tick_en;

    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_stage
            localparam int DV = (g == 0) ? DIV0 : (g == 1) ? DIV1 : DIV2;
            localparam int SW = $clog2(DV);

            logic [SW-1:0] cnt_d, cnt_q;
            logic          wrap;

            always_comb begin
                cnt_d = cnt_q;
                wrap  = stage_en[g] && (cnt_q == SW'(DV - 1));
                if (stage_en[g]) cnt_d = wrap ? '0 : cnt_q + SW'(1);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign stage_en[g+1] = wrap;
        end
    endgenerate

    assign sec_pulse = stage_en[NSTG] | test_sec_en;

endmodule

// File: rtl/bcdcal_counter.sv
module bcdcal_counter
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_pulse,
    input  logic              load_en,
    input  logic [NFIELD-1:0] load_mask,
    input  caltime_t          load_val,
    output caltime_t          cnt
);
    caltime_t cnt_d, cnt_q;
    caltime_t merged;

    always_comb begin
        merged = cnt_q;
        if (load_en) begin
            for (int i = 0; i < NFIELD; i++) begin
                if (load_mask[i]) merged[i*8 +: 8] = load_val[i*8 +: 8];
            end
        end
        cnt_d = sec_pulse ? step_second(merged) : merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= TIME_AT_RESET;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/bcdcal_regfile.sv
module bcdcal_regfile
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              sec_pulse,
    input  caltime_t          cnt,
    output logic              load_en,
    output logic [NFIELD-1:0] load_mask,
    output caltime_t          load_val,
    output logic              refresh_en,
    output logic              hold,
    output logic [7:0]        shown_sec
);
    typedef struct packed {
        caltime_t          shown;
        logic              hold;
        logic              h24;
        logic [NFIELD-1:0] dirty;
        logic              pend;
        logic [7:0]        rdata;
    } rf_state_t;

    rf_state_t s_d, s_q;

    logic [3:0] wsel;
    logic [2:0] widx;
    logic [7:0] rd_val;

    assign wsel = field_of(bus_addr);
    assign widx = wsel[2:0];

    function automatic caltime_t present(input caltime_t t, input logic h24);
        caltime_t r;
        r    = t;
        r.hr = h24 ? t.hr : hr24_to_12(t.hr);
        return r;
    endfunction

    always_comb begin
        if (bus_addr == A_CTRL)
            rd_val = {4'b0, s_q.hold, 1'b0, s_q.h24, 1'b0};
        else if (wsel[3])
            rd_val = s_q.shown[{widx, 3'b000} +: 8] & field_mask(widx, s_q.h24);
        else
            rd_val = 8'h00;
    end

    always_comb begin
        s_d       = s_q;
        load_en   = 1'b0;
        load_mask = '0;

        if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                s_d.hold = bus_wdata[HOLD_BIT];
                s_d.h24  = bus_wdata[H24_BIT];
                if (s_q.hold && !bus_wdata[HOLD_BIT]) begin
                    load_en   = 1'b1;
                    load_mask = s_q.dirty;
                    s_d.dirty = '0;
                end
            end else if (wsel[3]) begin
                s_d.shown[{widx, 3'b000} +: 8] = bus_wdata & field_mask(widx, s_q.h24);
                if (s_q.hold) s_d.dirty[widx] = 1'b1;
            end
        end

        // the refresh decided at the last step lands regardless of a newer hold
        if (s_q.pend) s_d.shown = present(cnt, s_q.h24);

        s_d.pend = sec_pulse && !s_q.hold;

        if (bus_rd) s_d.rdata = rd_val;
    end

    always_comb begin
        load_val    = s_q.shown;
        load_val.hr = s_q.h24 ? (s_q.shown.hr & 8'h3F) : hr12_to_24(s_q.shown.hr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.shown <= present(TIME_AT_RESET, 1'b0);
            s_q.hold  <= 1'b0;
            s_q.h24   <= 1'b0;
            s_q.dirty <= '0;
            s_q.pend  <= 1'b0;
            s_q.rdata <= 8'h00;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = s_q.rdata;
    assign refresh_en = s_q.pend;
    assign hold       = s_q.hold;
    assign shown_sec  = s_q.shown.sec;

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
    import bcdcal_pkg::*;
#(
    parameter int DIV0 = 8,
    parameter int DIV1 = 64,
    parameter int DIV2 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick32k_en,
    input  logic       fast_sec_en,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata
);
    logic              sec_pulse;
    logic              load_en;
    logic [NFIELD-1:0] load_mask;
    caltime_t          load_val;
    caltime_t          cnt;
    logic              refresh_en;
    logic              inhibit;
    logic [7:0]        shown_sec;

    bcdcal_prescale #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick32k_en),
        .test_sec_en (fast_sec_en),
        .sec_pulse   (sec_pulse)
    );

    bcdcal_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .load_en   (load_en),
        .load_mask (load_mask),
        .load_val  (load_val),
        .cnt       (cnt)
    );

    bcdcal_regfile u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .sec_pulse  (sec_pulse),
        .cnt        (cnt),
        .load_en    (load_en),
        .load_mask  (load_mask),
        .load_val   (load_val),
        .refresh_en (refresh_en),
        .hold       (inhibit),
        .shown_sec  (shown_sec)
    );

endmodule

// File: rtl/bcdcal_chk.sv
module bcdcal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick32k_en,
    input logic       fast_sec_en,
    input logic       sec_pulse,
    input logic       load_en,
    input logic       refresh_en,
    input logic       inhibit,
    input logic [7:0] cnt_sec,
    input logic [7:0] shown_sec,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata
);
    AST_DIV_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !fast_sec_en) |-> tick32k_en); // R1

    AST_SEC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !load_en) |=> $stable(cnt_sec)); // R2

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R3

    AST_STEP_REFRESHES: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !inhibit) |=> refresh_en); // R4

    AST_FROZEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !refresh_en && !bus_wr) |=> $stable(shown_sec)); // R5

    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !inhibit); // R7
endmodule

bind bcdcal_top bcdcal_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick32k_en (tick32k_en),
    .fast_sec_en(fast_sec_en),
    .sec_pulse  (sec_pulse),
    .load_en    (load_en),
    .refresh_en (refresh_en),
    .inhibit    (inhibit),
    .cnt_sec    (cnt.sec),
    .shown_sec  (shown_sec),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata)
);

// File: tb/sim_bcdcal_top.sv
`timescale 1ns/1ps
module sim_bcdcal_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick32k_en = 1'b0;
    logic       fast_sec_en = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int m_s, m_mi, m_h, m_d, m_w, m_mo, m_y, m_c;
    bit m_24;

    always #4 clk = ~clk;

    bcdcal_top u0 (
        .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .fast_sec_en(fast_sec_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] exp_hr(input int h, input bit h24);
        if (h24)          return to_bcd(h);
        else if (h == 0)  return 8'h12;
        else if (h < 12)  return to_bcd(h);
        else if (h == 12) return 8'h92;
        else              return 8'h80 | to_bcd(h - 12);
    endfunction

    function automatic int mdays(input int mo, input int y);
        case (mo)
            2:             return (y % 4 == 0) ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    task automatic model_tick();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_w = (m_w == 7) ? 1 : m_w + 1;
                    m_d++;
                    if (m_d > mdays(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y++;
                            if (m_y == 100) begin
                                m_y = 0;
                                m_c = (m_c == 99) ? 0 : m_c + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string what);
        logic [7:0] v;
        rd(a, v);
        chk(v, exp, what);
    endtask

    task automatic step();
        @(negedge clk);
        fast_sec_en = 1'b1;
        @(negedge clk);
        fast_sec_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        rd_chk(4'h0, to_bcd(m_s), {tag, " seconds"});
        rd_chk(4'h2, to_bcd(m_mi), {tag, " minutes"});
        rd_chk(4'h4, exp_hr(m_h, m_24), {tag, " hours"});
        rd_chk(4'h6, to_bcd(m_d), {tag, " date"});
        rd_chk(4'h8, to_bcd(m_w), {tag, " weekday"});
        rd_chk(4'h9, to_bcd(m_mo), {tag, " month"});
        rd_chk(4'hA, to_bcd(m_y), {tag, " year"});
        rd_chk(4'hF, to_bcd(m_c), {tag, " century"});
    endtask

    task automatic set_time(input bit h24, input int c, input int y, input int mo,
                            input int d, input int w, input int h, input int mi, input int s);
        logic [7:0] ctl;
        ctl = h24 ? 8'h02 : 8'h00;
        wr(4'hE, ctl | 8'h08);
        wr(4'h0, to_bcd(s));
        wr(4'h2, to_bcd(mi));
        wr(4'h4, exp_hr(h, h24));
        wr(4'h6, to_bcd(d));
        wr(4'h8, to_bcd(w));
        wr(4'h9, to_bcd(mo));
        wr(4'hA, to_bcd(y));
        wr(4'hF, to_bcd(c));
        wr(4'hE, ctl);
        m_24 = h24; m_c = c; m_y = y; m_mo = mo; m_d = d; m_w = w;
        m_h = h; m_mi = mi; m_s = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int saved;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R14 reset state
        m_24 = 0; m_c = 20; m_y = 0; m_mo = 1; m_d = 1; m_w = 7; m_h = 0; m_mi = 0; m_s = 0;
        check_all("R14");
        rd_chk(4'hE, 8'h00, "R14 control");
        rd_chk(4'h1, 8'h00, "R3 unmapped 0x1");

        // R1 divider chain: 32767 enables give no step, the 32768th does
        @(negedge clk);
        tick32k_en = 1'b1;
        repeat (32767) @(negedge clk);
        tick32k_en = 1'b0;
        @(negedge clk);
        rd_chk(4'h0, 8'h00, "R1 no step before 32768");
        @(negedge clk);
        tick32k_en = 1'b1;
        @(negedge clk);
        tick32k_en = 1'b0;
        @(negedge clk);
        model_tick();
        rd_chk(4'h0, 8'h01, "R1 step at 32768");

        // R2 test step
        step(); model_tick();
        step(); model_tick();
        check_all("R2");

        // R3 masks and unmapped addresses
        wr(4'hE, 8'h08);
        wr(4'h0, 8'hFF);
        rd_chk(4'h0, 8'h7F, "R3 seconds mask");
        wr(4'h8, 8'hFF);
        rd_chk(4'h8, 8'h07, "R3 weekday mask");
        wr(4'h3, 8'hAA);
        rd_chk(4'h3, 8'h00, "R3 unmapped 0x3");
        wr(4'hE, 8'hFF);
        rd_chk(4'hE, 8'h0A, "R3 control mask");

        // R9 12-hour form
        set_time(0, 20, 24, 3, 15, 3, 11, 59, 59);
        step(); model_tick();
        rd_chk(4'h4, 8'h92, "R9 11AM to 12PM");
        check_all("R9 noon");
        set_time(0, 20, 24, 3, 15, 3, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h4, 8'h12, "R9 11PM to 12AM");
        rd_chk(4'h6, 8'h16, "R9 date advance");

        // R10 R12 R13 year and century rollover in 24-hour form
        set_time(1, 20, 99, 12, 31, 7, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h4, 8'h00, "R10 midnight");
        rd_chk(4'h8, 8'h01, "R12 weekday wrap");
        rd_chk(4'hA, 8'h00, "R13 year wrap");
        rd_chk(4'hF, 8'h21, "R13 century carry");
        check_all("R10");

        // R11 month lengths
        set_time(1, 20, 23, 2, 28, 2, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h9, 8'h03, "R11 Feb non-leap month");
        rd_chk(4'h6, 8'h01, "R11 Feb non-leap date");
        set_time(1, 20, 24, 2, 28, 4, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h6, 8'h29, "R11 Feb leap 29");
        set_time(1, 20, 24, 2, 29, 5, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h9, 8'h03, "R11 leap Mar");
        set_time(1, 20, 24, 4, 30, 5, 23, 59, 59);
        step(); model_tick();
        check_all("R11 30-day");
        set_time(1, 20, 24, 1, 30, 5, 23, 59, 59);
        step(); model_tick();
        rd_chk(4'h6, 8'h31, "R11 Jan 31");

        // R6 hold set in the same cycle as a step
        set_time(1, 20, 25, 6, 10, 2, 10, 20, 30);
        @(negedge clk);
        fast_sec_en = 1'b1; bus_addr = 4'hE; bus_wdata = 8'h0A; bus_wr = 1'b1;
        @(negedge clk);
        fast_sec_en = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        model_tick();
        rd_chk(4'h0, to_bcd(m_s), "R6 refresh lands");
        saved = m_s;
        // R5 frozen window, running counters
        step(); model_tick();
        step(); model_tick();
        rd_chk(4'h0, to_bcd(saved), "R5 window frozen");
        wr(4'hE, 8'h02);
        step(); model_tick();
        check_all("R5 counters kept running");

        // R7 only written fields load
        wr(4'hE, 8'h0A);
        wr(4'h2, 8'h45);
        step(); model_tick();
        step(); model_tick();
        step(); model_tick();
        wr(4'hE, 8'h02);
        m_mi = 45;
        step(); model_tick();
        check_all("R7 partial load");

        // R8 write without hold is discarded
        wr(4'h2, 8'h07);
        step(); model_tick();
        check_all("R8 unheld write");

        // R4 seeded random settings near boundaries, both hour forms
        for (int it = 0; it < 40; it++) begin
            automatic bit h24 = 1'($urandom % 2);
            automatic int y   = $urandom % 100;
            automatic int mo  = 1 + $urandom % 12;
            automatic int d   = mdays(mo, y) - $urandom % 2;
            automatic int h   = (it % 3 == 0) ? 23 : $urandom % 24;
            automatic int mi  = 58 + $urandom % 2;
            automatic int s   = 55 + $urandom % 5;
            automatic int n   = 1 + $urandom % 5;
            set_time(h24, 19 + $urandom % 3, y, mo, d, 1 + $urandom % 7, h, mi, s);
            for (int k = 0; k < n; k++) begin
                step(); model_tick();
            end
            check_all("R4 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule